// File: doc/BRIEF.md
# Halfword Load Address and Formatting Unit

This pipeline stage serves halfword loads. It adds a base register value to either an index register value or a sign-extended 16-bit displacement to form the effective address. It then turns the big-endian memory halfword into a 32-bit register result in one of three ways: sign-extended, zero-padded or byte-swapped. The same stage also handles the two load-immediate forms. For update loads it produces a second write that stores the effective address back into the base register. An update whose encoding is illegal is flagged, and its second write is dropped.

Each operation arrives as one beat on a valid/ready input stream. Each result leaves as one beat on a valid/ready output stream, through a single register slice. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the slice is empty or the downstream consumer takes the held beat in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new beat is taken.

Top module: `hl_load_stage`

## Requirements
- R1: With `use_index` low, `ea_out` equals the base value plus `disp` sign-extended from 16 bits, modulo 2^32.
- R2: With `use_index` high, `ea_out` equals the base value plus `index_val`, modulo 2^32.
- R3: When `base_sel` is 0, the base operand is the constant 0 and `base_val` is ignored.
- R4: Kind code 0 (algebraic) gives `rt_data` = `mem_half` in bits 15:0, with bit 15 of `mem_half` copied into bits 31:16.
- R5: Kind code 1 (zero-padded) gives `rt_data` = `mem_half` in bits 15:0, with zeros in bits 31:16.
- R6: Kind code 2 (byte-reversed) gives `rt_data` bits 15:8 = `mem_half[7:0]` (the byte at EA+1) and bits 7:0 = `mem_half[15:8]` (the byte at EA), with zeros above.
- R7: Kind code 3 gives `rt_data` = `disp` sign-extended. Kind code 4 gives `rt_data` = `disp` in bits 31:16 with zeros below. For both codes `upd_req` has no effect: `upd_we` and `bad_form` stay 0.
- R8: For a load kind (0 to 2) with `upd_req` high and a legal form, `upd_we` is 1, `upd_idx` equals `base_sel`, and the value to write is `ea_out`.
- R9: For a load kind with `upd_req` high, the form is illegal when `base_sel` is 0 or `base_sel` equals `tgt_sel`. In that case `bad_form` is 1 and `upd_we` is 0. `bad_form` is 0 in every other case.
- R10: A beat accepted at a rising edge shows its results, with `out_valid` high, right after that edge. `rt_idx` equals the beat's `tgt_sel`.
- R11: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs stay stable.
- R12: A synchronous active-high `rst` clears `out_valid`, which leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat |
| kind | input | 3 | Operation code (0 alg, 1 zero, 2 byte-rev, 3 imm, 4 imm-high) |
| base_sel | input | 5 | Base register index; 0 means constant zero |
| tgt_sel | input | 5 | Target register index |
| base_val | input | 32 | Base register value |
| use_index | input | 1 | Add index value instead of displacement |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Displacement or immediate |
| upd_req | input | 1 | Update form requested |
| mem_half | input | 16 | Memory halfword, byte at EA in bits 15:8 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| ea_out | output | 32 | Effective address, also the base update value |
| rt_data | output | 32 | Formatted target register value |
| rt_idx | output | 5 | Target register index |
| upd_we | output | 1 | Base update write enable |
| upd_idx | output | 5 | Base register to update |
| bad_form | output | 1 | Illegal update form detected |

## Verification
The target write and the base update leave in the same output beat. They collide when `base_sel` equals `tgt_sel`. A sweep runs every kind against several halfwords, both address sources, and base and target choices that are equal, distinct or zero, with `upd_req` both on and off. Each beat compares the formatted result, the address, the suppression of the update write and the illegal-form flag against values computed from the rules. A separate sequence stalls the consumer while a second beat waits. It checks that the held beat stays frozen and that the waiting beat comes out intact once the stall ends.

// File: rtl/hl_pkg.sv
package hl_pkg;
  typedef enum logic [2:0] {
    LK_ALG   = 3'd0,
    LK_ZX    = 3'd1,
    LK_BREV  = 3'd2,
    LK_IMM   = 3'd3,
    LK_IMMHI = 3'd4
  } ld_kind_e;
endpackage

// File: rtl/hl_agen.sv
module hl_agen #(
  parameter int XLEN = 32,
  parameter int DW   = 16
) (
  input  logic [XLEN-1:0] base,
  input  logic            base_zero,
  input  logic            use_idx,
  input  logic [XLEN-1:0] idx,
  input  logic [DW-1:0]   disp,
  output logic [XLEN-1:0] ea
);
  localparam int EXT = XLEN - DW;
  logic [XLEN-1:0] off, b_eff;
  always_comb begin
    off   = use_idx ? idx : {{EXT{disp[DW-1]}}, disp};
    b_eff = base_zero ? '0 : base;
    ea    = b_eff + off;
  end
endmodule

// File: rtl/hl_fmt.sv
module hl_fmt #(
  parameter int XLEN = 32,
  parameter int HW   = 16
) (
  input  logic [2:0]      kind,
  input  logic [HW-1:0]   mem,
  input  logic [HW-1:0]   imm,
  output logic [XLEN-1:0] res
);
  import hl_pkg::*;
  localparam int NB  = HW / 8;
  localparam int EXT = XLEN - HW;
  logic [HW-1:0] swapped;

  // byte at lowest address lands in the least significant lane
  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[b*8 +: 8] = mem[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    unique case (kind)
      LK_ALG:   res = {{EXT{mem[HW-1]}}, mem};
      LK_ZX:    res = {{EXT{1'b0}}, mem};
      LK_BREV:  res = {{EXT{1'b0}}, swapped};
      LK_IMM:   res = {{EXT{imm[HW-1]}}, imm};
      LK_IMMHI: res = {imm, {EXT{1'b0}}};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/hl_upd_chk.sv
module hl_upd_chk #(
  parameter int RW = 5
) (
  input  logic [2:0]    kind,
  input  logic          upd_req,
  input  logic [RW-1:0] base_sel,
  input  logic [RW-1:0] tgt_sel,
  output logic          we,
  output logic          bad
);
  import hl_pkg::*;
  logic is_load, illegal;
  always_comb begin
    is_load = (kind == LK_ALG) || (kind == LK_ZX) || (kind == LK_BREV);
    illegal = (base_sel == '0) || (base_sel == tgt_sel);
    bad     = is_load && upd_req && illegal;
    we      = is_load && upd_req && !illegal;
  end
endmodule

// File: rtl/hl_load_stage.sv
module hl_load_stage #(
  parameter int XLEN = 32,
  parameter int HW   = 16,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      kind,
  input  logic [RW-1:0]   base_sel,
  input  logic [RW-1:0]   tgt_sel,
  input  logic [XLEN-1:0] base_val,
  input  logic            use_index,
  input  logic [XLEN-1:0] index_val,
  input  logic [HW-1:0]   disp,
  input  logic            upd_req,
  input  logic [HW-1:0]   mem_half,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] ea_out,
  output logic [XLEN-1:0] rt_data,
  output logic [RW-1:0]   rt_idx,
  output logic            upd_we,
  output logic [RW-1:0]   upd_idx,
  output logic            bad_form
);
  import hl_pkg::*;

  logic [XLEN-1:0] ea_c, res_c;
  logic            we_c, bad_c, accept;
  logic [2:0]      kind_q;

  hl_agen #(.XLEN(XLEN), .DW(HW)) u_agen (
    .base(base_val), .base_zero(base_sel == '0), .use_idx(use_index),
    .idx(index_val), .disp(disp), .ea(ea_c)
  );

  hl_fmt #(.XLEN(XLEN), .HW(HW)) u_fmt (
    .kind(kind), .mem(mem_half), .imm(disp), .res(res_c)
  );

  hl_upd_chk #(.RW(RW)) u_chk (
    .kind(kind), .upd_req(upd_req), .base_sel(base_sel), .tgt_sel(tgt_sel),
    .we(we_c), .bad(bad_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea_out    <= '0;
      rt_data   <= '0;
      rt_idx    <= '0;
      upd_we    <= 1'b0;
      upd_idx   <= '0;
      bad_form  <= 1'b0;
      kind_q    <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        ea_out    <= ea_c;
        rt_data   <= res_c;
        rt_idx    <= tgt_sel;
        upd_we    <= we_c;
        upd_idx   <= base_sel;
        bad_form  <= bad_c;
        kind_q    <= kind;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(ea_out) && $stable(rt_data) && $stable(upd_we) && $stable(rt_idx));

  // R9
  no_bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && upd_we |-> (upd_idx != '0) && (upd_idx != rt_idx) && !bad_form);

  // R5
  zx_upper_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (kind_q == LK_ZX || kind_q == LK_BREV) |-> rt_data[XLEN-1:HW] == '0);

  // R7
  imm_no_upd_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (kind_q == LK_IMM || kind_q == LK_IMMHI) |-> !upd_we && !bad_form);

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R12
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/sim_hl_load_stage.sv
module sim_hl_load_stage;
  localparam int CLK_NS = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 1, in_ready, out_valid;
  logic [2:0] kind = 0;
  logic [4:0] base_sel = 0, tgt_sel = 0, rt_idx, upd_idx;
  logic [31:0] base_val = 0, index_val = 0, ea_out, rt_data;
  logic use_index = 0, upd_req = 0, upd_we, bad_form;
  logic [15:0] disp = 0, mem_half = 0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  hl_load_stage u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .kind(kind),
    .base_sel(base_sel), .tgt_sel(tgt_sel), .base_val(base_val), .use_index(use_index),
    .index_val(index_val), .disp(disp), .upd_req(upd_req), .mem_half(mem_half),
    .out_valid(out_valid), .out_ready(out_ready), .ea_out(ea_out), .rt_data(rt_data),
    .rt_idx(rt_idx), .upd_we(upd_we), .upd_idx(upd_idx), .bad_form(bad_form)
  );

  logic [31:0] x_ea, x_rt;
  logic x_we, x_bad;
  logic [4:0] x_tgt, x_base;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model();
    logic [31:0] b, off;
    logic ld, illegal;
    b   = (base_sel == 0) ? 32'd0 : base_val;               // R3
    off = use_index ? index_val : {{16{disp[15]}}, disp};    // R1 R2
    x_ea = b + off;
    case (kind)
      3'd0: x_rt = {{16{mem_half[15]}}, mem_half};           // R4
      3'd1: x_rt = {16'd0, mem_half};                        // R5
      3'd2: x_rt = {16'd0, mem_half[7:0], mem_half[15:8]};   // R6
      3'd3: x_rt = {{16{disp[15]}}, disp};                   // R7
      3'd4: x_rt = {disp, 16'd0};
      default: x_rt = 0;
    endcase
    ld = kind <= 3'd2;
    illegal = (base_sel == 0) || (base_sel == tgt_sel);
    x_we = ld && upd_req && !illegal;                         // R8
    x_bad = ld && upd_req && illegal;                         // R9
    x_tgt = tgt_sel;
    x_base = base_sel;
  endtask

  task automatic cmp_out(input string req);
    check(req, {out_valid, ea_out, rt_data, rt_idx, upd_we, bad_form, (upd_we ? upd_idx : 5'd0)},
               {1'b1, x_ea, x_rt, x_tgt, x_we, x_bad, (x_we ? x_base : 5'd0)});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] sx_ea, sx_rt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R12 reset state", {out_valid, in_ready}, {1'b0, 1'b1});

    // streaming sweep, R1..R10
    for (int k = 0; k < 5; k++)
      for (int m = 0; m < 8; m++)
        for (int i = 0; i < 16; i++) begin
          kind      = k[2:0];
          mem_half  = (16'h8000 >> m) ^ (m[15:0] * 16'h1357);
          disp      = mem_half ^ 16'hA5C3 ^ i[15:0];
          base_val  = 32'h1000_0000 + m * 32'h111 + k;
          index_val = 32'hFFFF_FF00 + m * 3;
          use_index = i[0];
          base_sel  = i[1] ? 5'd0 : 5'd7;
          tgt_sel   = i[2] ? 5'd7 : 5'd9;
          upd_req   = i[3];
          in_valid  = 1;
          model();
          @(posedge clk);
          @(negedge clk);
          cmp_out("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 sweep");
        end
    in_valid = 0;
    @(negedge clk);
    check("R11 drain", out_valid, 1'b0);

    // back-pressure: R11
    out_ready = 0;
    kind = 3'd2; mem_half = 16'h12F0; disp = 16'hFFFC; base_val = 32'h40;
    use_index = 0; base_sel = 5'd3; tgt_sel = 5'd4; upd_req = 1; in_valid = 1;
    model();
    @(posedge clk); @(negedge clk);
    cmp_out("R11 first beat");
    check("R11 in_ready low under stall", in_ready, 1'b0);
    sx_ea = x_ea; sx_rt = x_rt;
    kind = 3'd0; mem_half = 16'h8001; disp = 16'h0010; base_val = 32'h100;
    base_sel = 5'd5; tgt_sel = 5'd5; upd_req = 1;
    repeat (3) @(negedge clk);
    check("R11 held stable", {out_valid, ea_out, rt_data}, {1'b1, sx_ea, sx_rt});
    model();
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    cmp_out("R11 second beat after release, R9 base equals target");
    in_valid = 0;
    @(posedge clk); @(negedge clk);
    check("R11 empty after consume", {out_valid, in_ready}, {1'b0, 1'b1});

    // reset mid-stream: R12
    in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0; rst = 1; out_ready = 0;
    @(posedge clk); @(negedge clk);
    check("R12 reset clears output", {out_valid, in_ready}, {1'b0, 1'b1});
    rst = 0; out_ready = 1;
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule